// File: doc/BRIEF.md
# Zig-Zag Coefficient Reorder with Nonzero AC Map

This block sits between the quantizer and the entropy coder of a baseline image encoder. It accepts one 8x8 block of signed quantized transform coefficients as a stream of 64 words in row-major order. It hands the block on, one coefficient per beat, in the standard 8x8 zig-zag scan order. On the first beat, the DC term is replaced by its difference from the DC value of the block that came before.

While a block loads, the block also builds a 63-bit map that flags every nonzero AC coefficient by its zig-zag position, together with the number of flagged positions. The entropy coder can then skip runs of zeros without scanning them. Two storage banks alternate, so the next block can load while the current one drains. A scan-start pulse clears the DC predictor at the beginning of each scan.

Top module: `zzr_top`

## Requirements
- R1: Output beat k (0 to 63) of a block carries the coefficient at zig-zag position k, with `out_pos` equal to k and `out_last` high only on beat 63. Zig-zag position k maps to row-major index r*8+c by walking the anti-diagonals r+c = 0..14. Even diagonals run from high row to low row, and odd diagonals from low row to high row.
- R2: Beat 0 carries raw DC minus the previous block's raw DC, as a two's-complement value COEF_W+1 bits wide.
- R3: The DC predictor is 0 after reset and after a `scan_start` pulse. If `scan_start` is high in the cycle that accepts a block's last coefficient, that block uses predictor 0, and the next block is predicted from that block's DC.
- R4: `out_map` bit (63-k) is 1 exactly when the coefficient at zig-zag position k (1 to 63) is nonzero. Position 1 is therefore in bit 62 and position 63 in bit 0. The DC term has no bit.
- R5: `out_nz_count` equals the number of nonzero AC coefficients in the block being output.
- R6: While `out_valid` is high and `out_ready` is low, `out_coef`, `out_pos`, `out_last`, `out_map` and `out_nz_count` hold their values.
- R7: A second block can be fully loaded while the first is still waiting at the output. With two blocks held, `in_ready` is low. Cycles with `in_valid` low write nothing.
- R8: After reset, `out_valid` is 0 and `in_ready` is 1.
- R9: AC coefficients appear on `out_coef` sign-extended to COEF_W+1 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_start | input | 1 | Clears the DC predictor |
| in_valid | input | 1 | Input coefficient present |
| in_ready | output | 1 | A write bank is free |
| in_coef | input | COEF_W | Coefficient, row-major order |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_coef | output | COEF_W+1 | Zig-zag coefficient, or DC difference on beat 0 |
| out_pos | output | 6 | Zig-zag position of the beat |
| out_last | output | 1 | Beat 63 of the block |
| out_map | output | 63 | Nonzero AC flags, position 1 in the MSB |
| out_nz_count | output | 7 | Count of nonzero AC coefficients |

## Verification
The bench builds the block with its default COEF_W of 16. This reaches the full 16-bit range at both ends: a DC step from -32768 to 32767 gives a difference of 65535, which needs the seventeenth bit. Negative extremes check the AC sign extension. Blocks with a single nonzero term at zig-zag position 1 or 63 pin down both ends of the map. An all-zero block gives an empty map and a count of zero.

// File: rtl/zzr_pkg.sv
package zzr_pkg;
    localparam int BLK   = 64;
    localparam int IDX_W = 6;
    localparam int AC_N  = BLK - 1;
    localparam int CNT_W = IDX_W + 1;

    typedef logic [BLK-1:0][IDX_W-1:0] idx_tab_t;

    // scan position -> row-major index, walking anti-diagonals
    function automatic idx_tab_t make_scan_tab();
        idx_tab_t t;
        int k, lo, hi, row;
        t = '0;
        k = 0;
        for (int s = 0; s < 15; s++) begin
            lo = (s > 7) ? s - 7 : 0;
            hi = (s < 7) ? s : 7;
            for (int m = 0; m < 8; m++) begin
                if (m <= hi - lo) begin
                    row = (s % 2 == 0) ? hi - m : lo + m;
                    t[IDX_W'(k)] = IDX_W'(row * 8 + s - row);
                    k++;
                end
            end
        end
        return t;
    endfunction

    function automatic idx_tab_t invert_tab(idx_tab_t fwd);
        idx_tab_t t;
        t = '0;
        for (int k = 0; k < BLK; k++) t[fwd[k]] = IDX_W'(k);
        return t;
    endfunction

    localparam idx_tab_t SCAN2NAT = make_scan_tab();
    localparam idx_tab_t NAT2SCAN = invert_tab(SCAN2NAT);
endpackage

// File: rtl/zzr_dcpred.sv
module zzr_dcpred
    import zzr_pkg::*;
#(
    parameter int COEF_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              load,
    input  logic [COEF_W-1:0] raw_dc,
    output logic [COEF_W-1:0] pred
);
    logic [COEF_W-1:0] prev_q;

    // a clear in the same cycle as a load applies to the loading block
    assign pred = clr ? '0 : prev_q;

    always_ff @(posedge clk) begin
        if (rst)       prev_q <= '0;
        else if (load) prev_q <= raw_dc;
        else if (clr)  prev_q <= '0;
    end
endmodule

// File: rtl/zzr_bank.sv
module zzr_bank
    import zzr_pkg::*;
#(
    parameter int COEF_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_nat,
    input  logic [COEF_W-1:0] wr_data,
    input  logic [COEF_W-1:0] pred_dc,
    input  logic [IDX_W-1:0]  rd_nat,
    output logic [COEF_W-1:0] rd_data,
    output logic [COEF_W-1:0] dc_raw,
    output logic [COEF_W:0]   dc_diff,
    output logic [AC_N-1:0]   ac_map,
    output logic [CNT_W-1:0]  nz_count
);
    logic [COEF_W-1:0] mem [BLK];
    logic [IDX_W-1:0]  wr_scan;
    logic [IDX_W-1:0]  map_bit;

    assign wr_scan = NAT2SCAN[wr_nat];
    assign map_bit = IDX_W'(AC_N) - wr_scan;
    assign rd_data = mem[rd_nat];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_nat] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dc_raw   <= '0;
            dc_diff  <= '0;
            ac_map   <= '0;
            nz_count <= '0;
        end else if (wr_en) begin
            if (wr_nat == '0) begin
                dc_raw   <= wr_data;
                ac_map   <= '0;
                nz_count <= '0;
            end else if (wr_data != '0) begin
                ac_map[map_bit] <= 1'b1;
                nz_count        <= nz_count + CNT_W'(1);
            end
            if (wr_nat == IDX_W'(AC_N))
                dc_diff <= {dc_raw[COEF_W-1], dc_raw} - {pred_dc[COEF_W-1], pred_dc};
        end
    end
endmodule

// File: rtl/zzr_top.sv
module zzr_top
    import zzr_pkg::*;
#(
    parameter int COEF_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scan_start,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [COEF_W-1:0] in_coef,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [COEF_W:0]   out_coef,
    output logic [IDX_W-1:0]  out_pos,
    output logic              out_last,
    output logic [AC_N-1:0]   out_map,
    output logic [CNT_W-1:0]  out_nz_count
);
    localparam int NBANK = 2;

    logic             wr_sel, rd_sel;
    logic [IDX_W-1:0] wr_cnt, rd_k;
    logic [NBANK-1:0] full;
    logic             wr_fire, rd_fire, blk_done;
    logic [COEF_W-1:0] pred;

    logic [COEF_W-1:0] b_rd   [NBANK];
    logic [COEF_W-1:0] b_dc   [NBANK];
    logic [COEF_W:0]   b_diff [NBANK];
    logic [AC_N-1:0]   b_map  [NBANK];
    logic [CNT_W-1:0]  b_cnt  [NBANK];

    assign in_ready  = !full[wr_sel];
    assign wr_fire   = in_valid && in_ready;
    assign blk_done  = wr_fire && (wr_cnt == IDX_W'(AC_N));
    assign out_valid = full[rd_sel];
    assign rd_fire   = out_valid && out_ready;

    zzr_dcpred #(.COEF_W(COEF_W)) u_pred (
        .clk(clk), .rst(rst), .clr(scan_start), .load(blk_done),
        .raw_dc(b_dc[wr_sel]), .pred(pred)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        zzr_bank #(.COEF_W(COEF_W)) u_bank (
            .clk(clk), .rst(rst),
            .wr_en(wr_fire && (wr_sel == 1'(b))),
            .wr_nat(wr_cnt), .wr_data(in_coef), .pred_dc(pred),
            .rd_nat(SCAN2NAT[rd_k]), .rd_data(b_rd[b]), .dc_raw(b_dc[b]),
            .dc_diff(b_diff[b]), .ac_map(b_map[b]), .nz_count(b_cnt[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_sel <= 1'b0;
            rd_sel <= 1'b0;
            wr_cnt <= '0;
            rd_k   <= '0;
            full   <= '0;
        end else begin
            if (wr_fire) wr_cnt <= wr_cnt + IDX_W'(1);
            if (blk_done) begin
                full[wr_sel] <= 1'b1;
                wr_sel       <= !wr_sel;
            end
            if (rd_fire) begin
                rd_k <= rd_k + IDX_W'(1);
                if (rd_k == IDX_W'(AC_N)) begin
                    full[rd_sel] <= 1'b0;
                    rd_sel       <= !rd_sel;
                end
            end
        end
    end

    assign out_coef     = (rd_k == '0) ? b_diff[rd_sel]
                                       : {b_rd[rd_sel][COEF_W-1], b_rd[rd_sel]};
    assign out_pos      = rd_k;
    assign out_last     = out_valid && (rd_k == IDX_W'(AC_N));
    assign out_map      = b_map[rd_sel];
    assign out_nz_count = b_cnt[rd_sel];

    // R6: stall holds the beat
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_coef)
            && $stable(out_pos) && $stable(out_map) && $stable(out_nz_count));

    // R5: count agrees with the map
    a_r5_count_map: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_nz_count == CNT_W'($countones(out_map)));

    // R1: positions advance one per accepted beat
    a_r1_pos_step: assert property (@(posedge clk) disable iff (rst)
        rd_fire && !out_last |=> out_valid && out_pos == $past(out_pos) + IDX_W'(1));

    // R1: a block always starts at position 0
    a_r1_start_pos0: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> out_pos == '0);

    // R7: both banks held means no input accepted
    a_r7_full_stall: assert property (@(posedge clk) disable iff (rst)
        (&full) |-> !in_ready);
endmodule

// File: tb/zzr_top_test.sv
module zzr_top_test;
    localparam int CW = 16;

    logic clk = 0, rst = 1, scan_start = 0, in_valid = 0, out_ready = 0;
    logic [CW-1:0] in_coef = '0;
    logic in_ready, out_valid, out_last;
    logic [CW:0] out_coef;
    logic [5:0] out_pos;
    logic [62:0] out_map;
    logic [6:0] out_nz_count;

    int checks = 0, failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    zzr_top #(.COEF_W(CW)) uut (
        .clk(clk), .rst(rst), .scan_start(scan_start), .in_valid(in_valid),
        .in_ready(in_ready), .in_coef(in_coef), .out_valid(out_valid),
        .out_ready(out_ready), .out_coef(out_coef), .out_pos(out_pos),
        .out_last(out_last), .out_map(out_map), .out_nz_count(out_nz_count)
    );

    // {pattern, stall mode}
    localparam int TBL [6][2] = '{'{1,0}, '{0,1}, '{2,2}, '{3,0}, '{4,1}, '{5,2}};

    function automatic int coef(int pat, int n);
        case (pat)
            0: return 0;
            1: return ((n * 37) % 201) - 100;
            2: return (n == 63) ? -1 : 0;
            3: return (n == 0) ? -32768 : ((n == 1) ? 32767 : 0);
            4: return (n == 0) ? 32767 : ((n % 2 == 1) ? -300 * n : 300 * n);
            default: return (n % 9 == 0) ? n * 100 - 3000 : 0;
        endcase
    endfunction

    // independent scan model: bounce along the diagonals
    function automatic int scan_nat(int k);
        int r = 0, c = 0;
        for (int i = 0; i < k; i++) begin
            if ((r + c) % 2 == 0) begin
                if (c == 7) r++; else if (r == 0) c++; else begin r--; c++; end
            end else begin
                if (r == 7) c++; else if (c == 0) r++; else begin r++; c--; end
            end
        end
        return r * 8 + c;
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic feed(int pat, bit clr_at_end);
        for (int n = 0; n < 64; n++) begin
            @(negedge clk);
            in_valid = 1;
            in_coef  = CW'(coef(pat, n));
            if (clr_at_end && n == 63) scan_start = 1;
            while (!in_ready) @(negedge clk);
        end
        @(negedge clk);
        in_valid   = 0;
        scan_start = 0;
    endtask

    task automatic drain(int pat, int stall, int prev);
        int k = 0, cyc = 0;
        bit held = 0;
        logic [CW:0] hv;
        logic [62:0] emap = '0;
        int ecnt = 0;
        for (int p = 1; p < 64; p++)
            if (coef(pat, scan_nat(p)) != 0) begin emap[63 - p] = 1; ecnt++; end
        while (k < 64) begin
            @(negedge clk);
            cyc++;
            out_ready = (stall == 0) || (cyc % (stall + 1) == 0);
            if (out_valid) begin
                if (held) chk(out_coef == hv, "R6 hold", 64'(out_coef), 64'(hv));
                if (out_ready) begin
                    if (k == 0) begin
                        chk(out_coef == 17'(coef(pat, 0) - prev), "R2 dc diff",
                            64'(out_coef), 64'(17'(coef(pat, 0) - prev)));
                        chk(out_map == emap, "R4 map", 64'(out_map), 64'(emap));
                        chk(out_nz_count == 7'(ecnt), "R5 count", 64'(out_nz_count), 64'(ecnt));
                    end else begin
                        chk(out_coef == 17'(coef(pat, scan_nat(k))), "R1 R9 coef",
                            64'(out_coef), 64'(17'(coef(pat, scan_nat(k)))));
                    end
                    chk(out_pos == 6'(k) && out_last == (k == 63), "R1 pos/last",
                        64'({out_last, out_pos}), 64'({k == 63, 6'(k)}));
                    k++;
                    held = 0;
                end else begin
                    held = 1;
                    hv   = out_coef;
                end
            end
        end
        @(negedge clk);
        out_ready = 0;
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int prev = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(out_valid == 0, "R8 valid", 64'(out_valid), 0);
        chk(in_ready == 1, "R8 ready", 64'(in_ready), 1);

        // table walk
        for (int t = 0; t < 6; t++) begin
            fork
                feed(TBL[t][0], 0);
                drain(TBL[t][0], TBL[t][1], prev);
            join
            prev = coef(TBL[t][0], 0);
        end

        // R7: two blocks held, idle writes ignored
        out_ready = 0;
        feed(1, 0);
        feed(5, 0);
        @(negedge clk);
        chk(in_ready == 0, "R7 full", 64'(in_ready), 0);
        in_coef = 16'h7777;
        repeat (5) @(negedge clk);
        chk(out_valid && out_pos == 0, "R7 wait", 64'({out_valid, out_pos}), 64'h40);
        drain(1, 0, prev);
        drain(5, 1, coef(1, 0));
        prev = coef(5, 0);

        // R3: scan-start pulse between blocks
        @(negedge clk); scan_start = 1;
        @(negedge clk); scan_start = 0;
        fork feed(4, 0); drain(4, 0, 0); join
        // R3: clear coinciding with the last coefficient
        fork feed(1, 1); drain(1, 0, 0); join
        fork feed(5, 0); drain(5, 0, coef(1, 0)); join

        // R8: reset again in the middle of a load
        @(negedge clk); in_valid = 1;
        repeat (10) @(negedge clk);
        in_valid = 0; rst = 1;
        @(negedge clk); rst = 0;
        @(negedge clk);
        chk(out_valid == 0 && in_ready == 1, "R8 rereset", 64'({out_valid, in_ready}), 1);
        fork feed(3, 0); drain(3, 0, 0); join

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule